// File: doc/BRIEF.md
# End-of-Stream Trailing Byte Controller

This block decides when a streaming transform engine may signal end-of-stream to its consumer. The engine reports, every cycle, how much it reads from its input and how much it writes to its output. The upstream source raises an end-of-input marker. From then on the engine does not stall on reads. It keeps running on zero-valued filler bytes, so that data still held in its registers drains out. The controller raises its end-of-stream flag once a configured number of trailing bytes has passed.

The trailing bytes are counted on one of two sides, chosen when the engine is started. On the read side, the consumed byte amounts are counted. On the write side, the produced byte amounts are counted, and the flag rides on the write that completes the count. A start pulse loads the configuration and clears all flush state. After reset the block behaves as if it was started with read-side counting and zero trailing bytes. The data path itself lies outside this block.

Top module: `eos_trail_ctrl`

## Requirements
- R1: The read and write size codes map to byte amounts as follows: 2'b00 is 0 bytes, 2'b01 is 1 byte, 2'b10 is 2 bytes and 2'b11 is 4 bytes.
- R2: `zero_fill` rises in the cycle after `in_eof` is accepted. It stays high until the next `start` or reset, telling the engine to serve reads immediately with zero bytes.
- R3: Transfers made before `in_eof` and in the cycle that `in_eof` is high are not counted as trailing bytes.
- R4: With read-side counting (`cfg_side` = 0), `out_eof` is high in the cycle after the read that brings the counted total to at least the trailing count. With a trailing count of 0 it is high in the cycle after `in_eof`. Write amounts have no effect in this mode.
- R5: With write-side counting (`cfg_side` = 1), `out_eof` is high in the same cycle as the non-zero write that brings the counted total to at least the trailing count. With a trailing count of 0 this is the first non-zero write after `in_eof`. Reads and zero-size writes never raise it in this mode.
- R6: The trailing-byte total saturates at 2^TRAIL_W-1 instead of wrapping, so a multi-byte transfer that overshoots still ends the stream.
- R7: `out_eof` is high for exactly one cycle per stream and does not rise again until a new `start`.
- R8: `start` loads `cfg_side` and `cfg_trail` and clears the flush state. Its effect appears in the next cycle, and an `in_eof` in the same cycle as `start` is ignored.
- R9: Reset drives `out_eof` and `zero_fill` low and selects read-side counting with a trailing count of 0.
- R10: `out_eof` is never high while `zero_fill` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new stream: load configuration, clear state |
| cfg_side | input | 1 | Counting side: 0 counts reads, 1 counts writes |
| cfg_trail | input | TRAIL_W | Number of trailing dummy bytes |
| in_eof | input | 1 | Upstream end-of-input marker |
| rd_size | input | 2 | Size code of this cycle's read (R1 encoding) |
| wr_size | input | 2 | Size code of this cycle's write (R1 encoding) |
| zero_fill | output | 1 | Reads are served immediately with zero bytes |
| out_eof | output | 1 | End-of-stream flag for the downstream consumer |

## Verification
The results fall due at three different delays. `zero_fill` follows `in_eof` by one cycle. A read-side `out_eof` follows the counting read by one registered cycle. A write-side `out_eof` is combinational with the write that carries it, and `start` changes behaviour only from the next cycle. The bench drives every input on the falling edge and samples 1 ns later, so each sample shows the registered state left by the preceding rising edge together with the current cycle's transfer amounts. Every expected cycle is counted from the cycle in which `in_eof` is driven: 1+ceil(T/b) for read-side counting and max(1, ceil(T/b)) for write-side counting.

// File: rtl/eos_trail_pkg.sv
package eos_trail_pkg;

    localparam int BYTES_W = 3;

    typedef enum logic [1:0] {
        XF_NONE = 2'b00,
        XF_BYTE = 2'b01,
        XF_HALF = 2'b10,
        XF_WORD = 2'b11
    } xfer_code_e;

    typedef enum logic {
        SIDE_READ  = 1'b0,
        SIDE_WRITE = 1'b1
    } count_side_e;

    typedef struct packed {
        logic seen;   // end-of-input accepted, flush in progress
        logic sent;   // end-of-stream already delivered
    } eos_flags_t;

    function automatic logic [BYTES_W-1:0] code_to_bytes(input logic [1:0] code);
        case (xfer_code_e'(code))
            XF_BYTE: return BYTES_W'(1);
            XF_HALF: return BYTES_W'(2);
            XF_WORD: return BYTES_W'(4);
            default: return BYTES_W'(0);
        endcase
    endfunction

endpackage

// File: rtl/eos_size_decode.sv
module eos_size_decode
    import eos_trail_pkg::*;
(
    input  logic [1:0]         code,
    output logic [BYTES_W-1:0] bytes,
    output logic               active
);
    always_comb begin
        bytes  = code_to_bytes(code);
        active = (bytes != '0);
    end
endmodule

// File: rtl/eos_byte_counter.sv
module eos_byte_counter
    import eos_trail_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               en,
    input  logic [BYTES_W-1:0] add,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [CNT_W-1:0]   sum_sat
);
    localparam int SUM_W = CNT_W + 1;

    logic [SUM_W-1:0] sum_wide;

    always_comb begin
        sum_wide = {1'b0, cnt_q} + SUM_W'(add);
        sum_sat  = sum_wide[CNT_W] ? {CNT_W{1'b1}} : sum_wide[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= sum_sat;
        end
    end
endmodule

// File: rtl/eos_flag_ctrl.sv
module eos_flag_ctrl
    import eos_trail_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       in_eof,
    input  logic       fire,
    output eos_flags_t flags_q
);
    always_ff @(posedge clk) begin
        if (rst || start) begin
            flags_q <= '0;
        end else begin
            if (in_eof) flags_q.seen <= 1'b1;
            if (fire)   flags_q.sent <= 1'b1;
        end
    end
endmodule

// File: rtl/eos_trail_ctrl.sv
module eos_trail_ctrl
    import eos_trail_pkg::*;
#(
    parameter int TRAIL_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               cfg_side,
    input  logic [TRAIL_W-1:0] cfg_trail,
    input  logic               in_eof,
    input  logic [1:0]         rd_size,
    input  logic [1:0]         wr_size,
    output logic               zero_fill,
    output logic               out_eof
);
    localparam int N_SIDES = 2;
    localparam int SIDE_RD = 0;
    localparam int SIDE_WR = 1;

    count_side_e        side_q;
    logic [TRAIL_W-1:0] trail_q;

    logic [1:0]         size_code [N_SIDES];
    logic [BYTES_W-1:0] side_bytes [N_SIDES];
    logic               side_active [N_SIDES];

    logic [BYTES_W-1:0] add_bytes;
    logic [TRAIL_W-1:0] cnt_q;
    logic [TRAIL_W-1:0] cnt_next;
    eos_flags_t         flags_q;
    logic               armed;
    logic               fire;

    // configuration is captured at start; reset selects the defaults
    always_ff @(posedge clk) begin
        if (rst) begin
            side_q  <= SIDE_READ;
            trail_q <= '0;
        end else if (start) begin
            side_q  <= count_side_e'(cfg_side);
            trail_q <= cfg_trail;
        end
    end

    assign size_code[SIDE_RD] = rd_size;
    assign size_code[SIDE_WR] = wr_size;

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        eos_size_decode u_dec (
            .code   (size_code[s]),
            .bytes  (side_bytes[s]),
            .active (side_active[s])
        );
    end

    assign add_bytes = (side_q == SIDE_WRITE) ? side_bytes[SIDE_WR] : side_bytes[SIDE_RD];
    assign armed     = flags_q.seen && !flags_q.sent;

    eos_byte_counter #(.CNT_W(TRAIL_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr     (start),
        .en      (armed),
        .add     (add_bytes),
        .cnt_q   (cnt_q),
        .sum_sat (cnt_next)
    );

    always_comb begin
        if (side_q == SIDE_WRITE) begin
            fire = armed && side_active[SIDE_WR] && (cnt_next >= trail_q);
        end else begin
            fire = armed && (cnt_q >= trail_q);
        end
    end

    eos_flag_ctrl u_flags (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .in_eof  (in_eof),
        .fire    (fire),
        .flags_q (flags_q)
    );

    assign zero_fill = flags_q.seen;
    assign out_eof   = fire;
endmodule

// File: rtl/eos_trail_checker.sv
module eos_trail_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic in_eof,
    input logic zero_fill,
    input logic out_eof
);
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        out_eof |=> !out_eof);

    assert_fill_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (zero_fill && !start) |=> zero_fill);

    assert_fill_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(zero_fill) |-> ($past(in_eof) && !$past(start)));

    assert_start_clears_R8: assert property (@(posedge clk) disable iff (rst)
        start |=> (!zero_fill && !out_eof));

    assert_eof_needs_fill_R10: assert property (@(posedge clk) disable iff (rst)
        out_eof |-> zero_fill);

    assert_reset_quiet_R9: assert property (@(posedge clk)
        rst |=> (!zero_fill && !out_eof));
endmodule

bind eos_trail_ctrl eos_trail_checker u_eos_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .in_eof    (in_eof),
    .zero_fill (zero_fill),
    .out_eof   (out_eof)
);

// File: tb/test_eos_trail_ctrl.sv
module test_eos_trail_ctrl;
    localparam int TW    = 8;
    localparam int NVEC  = 13;
    localparam int WDOG  = 100000;

    // vectors: side, trailing count, size code, expected out_eof cycle after in_eof
    localparam logic      V_SIDE [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
                                            1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam int        V_TRL  [NVEC] = '{0, 5, 5, 8, 7, 0, 5, 5, 8, 3, 9, 255, 255};
    localparam logic [1:0] V_CODE [NVEC] = '{2'd1, 2'd1, 2'd2, 2'd3, 2'd3, 2'd1, 2'd1,
                                            2'd2, 2'd3, 2'd3, 2'd3, 2'd3, 2'd3};
    localparam int        V_OFF  [NVEC] = '{1, 6, 4, 3, 3, 1, 5, 3, 2, 1, 3, 65, 64};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          cfg_side = 1'b0;
    logic [TW-1:0] cfg_trail = '0;
    logic          in_eof = 1'b0;
    logic [1:0]    rd_size = 2'b00;
    logic [1:0]    wr_size = 2'b00;
    logic          zero_fill;
    logic          out_eof;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    eos_trail_ctrl #(.TRAIL_W(TW)) i_eos_trail_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_side  (cfg_side),
        .cfg_trail (cfg_trail),
        .in_eof    (in_eof),
        .rd_size   (rd_size),
        .wr_size   (wr_size),
        .zero_fill (zero_fill),
        .out_eof   (out_eof)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // advance to the next falling edge and let the sample settle
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_start(input bit side, input int trail);
        tick();
        start = 1'b1; cfg_side = side; cfg_trail = TW'(trail);
        rd_size = 2'b00; wr_size = 2'b00; in_eof = 1'b0;
        tick();
        start = 1'b0;
    endtask

    // one table entry: counted side gets the vector's code, other side moves 4 bytes
    task automatic run_vec(input int i);
        int first = -1;
        int pulses = 0;
        string rq;
        rq = V_SIDE[i] ? "R5" : "R4";
        do_start(V_SIDE[i], V_TRL[i]);
        rd_size = V_SIDE[i] ? 2'b11 : V_CODE[i];
        wr_size = V_SIDE[i] ? V_CODE[i] : 2'b11;
        for (int k = 0; k < 3; k++) begin
            #1;
            check(zero_fill == 1'b0 && out_eof == 1'b0, "R3 before eof", {zero_fill, out_eof}, 0);
            tick();
        end
        in_eof = 1'b1;
        #1;
        check(out_eof == 1'b0, "R3 eof cycle", out_eof, 0);
        for (int k = 1; k <= V_OFF[i] + 4; k++) begin
            tick();
            in_eof = 1'b0;
            #1;
            if (k == 1) check(zero_fill == 1'b1, "R2 fill rises", zero_fill, 1);
            if (out_eof) begin
                pulses++;
                if (first < 0) first = k;
            end
        end
        check(first == V_OFF[i], i >= 11 ? {rq, " R6 R1 timing"} : {rq, " R1 timing"}, first, V_OFF[i]);
        check(pulses == 1, "R7 pulse count", pulses, 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WDOG) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, WDOG);
                finish_run();
            end
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        #1;
        // R9: quiet outputs after reset
        check(zero_fill == 1'b0, "R9 zero_fill reset", zero_fill, 0);
        check(out_eof == 1'b0, "R9 out_eof reset", out_eof, 0);

        // R9 defaults: read side, zero trailing -> fires without any transfer
        tick();
        in_eof = 1'b1;
        tick();
        in_eof = 1'b0;
        #1;
        check(out_eof == 1'b1, "R9 default side/trail", out_eof, 1);
        tick(); #1;
        check(out_eof == 1'b0, "R7 single after default", out_eof, 0);

        for (int i = 0; i < NVEC; i++) run_vec(i);

        // R8: in_eof together with start is ignored
        tick();
        start = 1'b1; cfg_side = 1'b0; cfg_trail = '0; in_eof = 1'b1;
        tick();
        start = 1'b0; in_eof = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1;
            check(zero_fill == 1'b0 && out_eof == 1'b0, "R8 eof with start", {zero_fill, out_eof}, 0);
            tick();
        end

        // R8: start during a flush clears it
        do_start(1'b0, 20);
        rd_size = 2'b01;
        in_eof = 1'b1;
        tick(); in_eof = 1'b0;
        tick(); tick();
        #1;
        check(zero_fill == 1'b1, "R2 fill during flush", zero_fill, 1);
        start = 1'b1;
        tick(); start = 1'b0;
        #1;
        check(zero_fill == 1'b0, "R8 start clears fill", zero_fill, 0);
        check(out_eof == 1'b0, "R8 start clears eof", out_eof, 0);

        // R5: write side ignores reads and zero-size writes, fires on first real write
        do_start(1'b1, 0);
        rd_size = 2'b11; wr_size = 2'b00;
        in_eof = 1'b1;
        tick(); in_eof = 1'b0;
        begin
            int seen_eof = 0;
            for (int k = 0; k < 6; k++) begin
                #1;
                if (out_eof) seen_eof++;
                tick();
            end
            check(seen_eof == 0, "R5 reads ignored", seen_eof, 0);
        end
        wr_size = 2'b01;
        #1;
        check(out_eof == 1'b1, "R5 first write carries eof", out_eof, 1);
        tick(); #1;
        check(out_eof == 1'b0, "R7 no repeat", out_eof, 0);
        wr_size = 2'b00; rd_size = 2'b00;

        finish_run();
    end
endmodule